// File: doc/BRIEF.md
# Register-Sampled Horizontal Display Timing Generator

This block produces the horizontal timing of one video scanline from a free-running cycle counter. The counter advances at the system clock. At a fixed set of counter positions the block looks at two mode registers that the CPU can write: a resolution mode (low or high) and a refresh-rate mode (60 Hz or 50 Hz). These positions are called decision points. From what it sees there, the block drives a display-enable level, a blank level, a horizontal sync level and the length of the line in cycles. It also emits a one-cycle pulse at the start of every line.

No output is computed from the current mode continuously. Every output is decided only at a decision point. A program that rewrites a mode register in the middle of a line can therefore stretch, shorten or suppress display enable on that line. At every decision point the refresh-rate register is read in one cycle and the resolution register in the following cycle.

A 0 to 3 cycle phase offset delays every decision point. This models the phase relation between the timing logic and the CPU, which is fixed at power-up. The offset is loaded only while the power-on input is low, and a normal reset leaves it unchanged.

Top module: `hdt_timing`

## Requirements
- R1: While `rst_n` is low the outputs are: `h_o` 0, `blank_o` 1, `hsync_o` 0, `line_len_o` 508, and `sol_o` 1 (counter at 0). Both mode registers reset to low resolution and 60 Hz.
- R2: A write is made when `wr_en` is 1 during a cycle. `wr_sel` 0 selects the resolution register and `wr_sel` 1 selects the refresh-rate register. Only `wr_data[1]` is stored. For resolution, 0 means low and 2 means high. For refresh rate, 0 means 60 Hz and 2 means 50 Hz. A value written in cycle k is the register value from cycle k+1 on.
- R3: At decision point 54 the line length is set to 224 if resolution is high, otherwise to 512 if the rate is 50 Hz, otherwise to 508. The counter wraps from length−1 to 0, and each new line starts with length 508 until point 54 decides.
- R4: `h_o` is set at point 4 if resolution is high, at point 52 if the rate is 60 Hz, and at point 56 if the rate is 50 Hz with low resolution. A decision at point P is visible on the outputs while the counter holds P+phase+2.
- R5: `h_o` is cleared at point 164 if resolution is high, at point 372 if the rate is 60 Hz, and at point 376 if the rate is 50 Hz with low resolution.
- R6: `blank_o` is released at point 30 if resolution is low. It is set at point 184 if resolution is high and at point 450 if resolution is low.
- R7: With low resolution, `hsync_o` rises at point 462 and falls at point 502. The rise also clears `h_o`.
- R8: For decision point P, the refresh-rate register is read as it stands in counter cycle P+phase. The resolution register is read as it stands in cycle P+phase+1.
- R9: While `blank_o` is 1, the rate-driven sets of `h_o` at points 52 and 56 are suppressed.
- R10: `phase_i` is captured while `por_n` is low and is kept unchanged while `por_n` stays high, including through any `rst_n` pulse.
- R11: `sol_o` is 1 for exactly one cycle per line, in the cycle where the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on strobe, active low; loads the phase offset |
| rst_n | input | 1 | Asynchronous reset, active low; does not touch the phase |
| phase_i | input | 2 | Phase offset 0..3, captured while `por_n` is low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = resolution register, 1 = refresh-rate register |
| wr_data | input | 2 | Written value; bit 1 carries the mode |
| h_o | output | 1 | Horizontal display enable |
| blank_o | output | 1 | Blank level |
| hsync_o | output | 1 | Horizontal sync level |
| sol_o | output | 1 | Start-of-line pulse |
| line_len_o | output | 10 | Length of the current line in cycles |

## Verification
The bench rewrites a mode register one cycle before and exactly at a decision point. If a design read the register one cycle too late or too early, it would move `h_o`'s fall from 166 to 374, or from 374 to 464, or the reverse. The same line-level measurements check that resolution is read one cycle after the refresh rate. They also check that hsync ends a display enable that was left running. If a design dropped the blank suppression, a line whose blank was never released would still show display enable. If a design cleared the phase on reset, its edges would land two cycles early after a reset-only pulse. A high-resolution line must wrap at 224 and emit no sync or blank release.

// File: rtl/hdt_pkg.sv
package hdt_pkg;

  // Decision point indices
  localparam int NUM_PTS     = 12;
  localparam int PT_HI_ON    = 0;
  localparam int PT_BLK_OFF  = 1;
  localparam int PT_H60_ON   = 2;
  localparam int PT_LEN      = 3;
  localparam int PT_H50_ON   = 4;
  localparam int PT_HI_OFF   = 5;
  localparam int PT_HI_BLK   = 6;
  localparam int PT_H60_OFF  = 7;
  localparam int PT_H50_OFF  = 8;
  localparam int PT_LO_BLK   = 9;
  localparam int PT_SYNC_ON  = 10;
  localparam int PT_SYNC_OFF = 11;

  // Nominal counter position of each decision point
  function automatic int pt_pos(input int idx);
    case (idx)
      PT_HI_ON:    pt_pos = 4;
      PT_BLK_OFF:  pt_pos = 30;
      PT_H60_ON:   pt_pos = 52;
      PT_LEN:      pt_pos = 54;
      PT_H50_ON:   pt_pos = 56;
      PT_HI_OFF:   pt_pos = 164;
      PT_HI_BLK:   pt_pos = 184;
      PT_H60_OFF:  pt_pos = 372;
      PT_H50_OFF:  pt_pos = 376;
      PT_LO_BLK:   pt_pos = 450;
      PT_SYNC_ON:  pt_pos = 462;
      default:     pt_pos = 502;
    endcase
  endfunction

  // Register select codes
  localparam logic SEL_RES  = 1'b0;
  localparam logic SEL_FREQ = 1'b1;

  typedef struct packed {
    logic h;
    logic blank;
    logic hsync;
  } vid_t;

endpackage

// File: rtl/hdt_phase.sv
module hdt_phase #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic [PW-1:0] phase_i,
  output logic [PW-1:0] phase_o
);

  logic [PW-1:0] phase_q;

  // Loaded only during power-on; ordinary reset leaves it alone
  always_ff @(posedge clk) begin
    if (!por_n) phase_q <= phase_i;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/hdt_mode_regs.sv
module hdt_mode_regs
  import hdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [1:0] wr_data,
  output logic       res_hi_o,
  output logic       freq50_prev_o
);

  logic res_hi_q;
  logic freq50_q;
  logic freq50_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi_q      <= 1'b0;
      freq50_q      <= 1'b0;
      freq50_prev_q <= 1'b0;
    end else begin
      if (wr_en && (wr_sel == SEL_RES))  res_hi_q <= wr_data[1];
      if (wr_en && (wr_sel == SEL_FREQ)) freq50_q <= wr_data[1];
      // one-cycle-old copy: rate is judged a cycle ahead of resolution
      freq50_prev_q <= freq50_q;
    end
  end

  assign res_hi_o      = res_hi_q;
  assign freq50_prev_o = freq50_prev_q;

endmodule

// File: rtl/hdt_line_counter.sv
module hdt_line_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] cnt_o,
  output logic          sol_o,
  output logic          eol_o
);

  logic [CW-1:0] cnt_q;
  logic          eol;

  assign eol = (cnt_q == len_i - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (eol) cnt_q <= '0;
    else          cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
  assign sol_o = (cnt_q == '0);
  assign eol_o = eol;

endmodule

// File: rtl/hdt_decide.sv
module hdt_decide
  import hdt_pkg::*;
#(
  parameter int CW       = 10,
  parameter int PW       = 2,
  parameter int LEN_HI   = 224,
  parameter int LEN_LO60 = 508,
  parameter int LEN_LO50 = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [PW-1:0] phase_i,
  input  logic          eol_i,
  input  logic          res_hi_i,
  input  logic          freq50_prev_i,
  output vid_t          vid_o,
  output logic [CW-1:0] len_o
);

  logic [NUM_PTS-1:0] hit;
  vid_t               vid_q, vid_n;
  logic [CW-1:0]      len_q, len_n;

  // One comparator per decision point; evaluation cycle is P+phase+1
  for (genvar g = 0; g < NUM_PTS; g++) begin : g_pt
    localparam logic [CW-1:0] BASE = CW'(pt_pos(g) + 1);
    assign hit[g] = (cnt_i == BASE + CW'(phase_i));
  end

  always_comb begin
    vid_n = vid_q;
    len_n = len_q;

    if (hit[PT_HI_ON] && res_hi_i)                                 vid_n.h = 1'b1;
    if (hit[PT_H60_ON] && !freq50_prev_i && !vid_q.blank)          vid_n.h = 1'b1;
    if (hit[PT_H50_ON] && freq50_prev_i && !res_hi_i && !vid_q.blank) vid_n.h = 1'b1;

    if (hit[PT_HI_OFF] && res_hi_i)                                vid_n.h = 1'b0;
    if (hit[PT_H60_OFF] && !freq50_prev_i)                         vid_n.h = 1'b0;
    if (hit[PT_H50_OFF] && freq50_prev_i && !res_hi_i)             vid_n.h = 1'b0;

    if (hit[PT_BLK_OFF] && !res_hi_i)                              vid_n.blank = 1'b0;
    if (hit[PT_HI_BLK] && res_hi_i)                                vid_n.blank = 1'b1;
    if (hit[PT_LO_BLK] && !res_hi_i)                               vid_n.blank = 1'b1;

    if (hit[PT_SYNC_ON] && !res_hi_i) begin
      vid_n.hsync = 1'b1;
      vid_n.h     = 1'b0;
    end
    if (hit[PT_SYNC_OFF] && !res_hi_i)                             vid_n.hsync = 1'b0;

    if (eol_i) begin
      len_n = CW'(LEN_LO60);
    end else if (hit[PT_LEN]) begin
      if (res_hi_i)           len_n = CW'(LEN_HI);
      else if (freq50_prev_i) len_n = CW'(LEN_LO50);
      else                    len_n = CW'(LEN_LO60);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q <= '{h: 1'b0, blank: 1'b1, hsync: 1'b0};
      len_q <= CW'(LEN_LO60);
    end else begin
      vid_q <= vid_n;
      len_q <= len_n;
    end
  end

  assign vid_o = vid_q;
  assign len_o = len_q;

endmodule

// File: rtl/hdt_timing.sv
module hdt_timing
  import hdt_pkg::*;
#(
  parameter  int LEN_HI   = 224,
  parameter  int LEN_LO60 = 508,
  parameter  int LEN_LO50 = 512,
  parameter  int PW       = 2,
  localparam int CW       = $clog2(LEN_LO50 + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic [PW-1:0] phase_i,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [1:0]    wr_data,
  output logic          h_o,
  output logic          blank_o,
  output logic          hsync_o,
  output logic          sol_o,
  output logic [CW-1:0] line_len_o
);

  logic [PW-1:0] phase_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len;
  logic          eol;
  logic          res_hi;
  logic          freq50_prev;
  vid_t          vid;

  hdt_phase #(.PW(PW)) u_phase (
    .clk     (clk),
    .por_n   (por_n),
    .phase_i (phase_i),
    .phase_o (phase_q)
  );

  hdt_mode_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .res_hi_o      (res_hi),
    .freq50_prev_o (freq50_prev)
  );

  hdt_line_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .len_i (len),
    .cnt_o (cnt),
    .sol_o (sol_o),
    .eol_o (eol)
  );

  hdt_decide #(
    .CW(CW), .PW(PW), .LEN_HI(LEN_HI), .LEN_LO60(LEN_LO60), .LEN_LO50(LEN_LO50)
  ) u_decide (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_i         (cnt),
    .phase_i       (phase_q),
    .eol_i         (eol),
    .res_hi_i      (res_hi),
    .freq50_prev_i (freq50_prev),
    .vid_o         (vid),
    .len_o         (len)
  );

  assign h_o        = vid.h;
  assign blank_o    = vid.blank;
  assign hsync_o    = vid.hsync;
  assign line_len_o = len;

endmodule

// File: rtl/hdt_timing_chk.sv
module hdt_timing_chk #(
  parameter int CW       = 10,
  parameter int PW       = 2,
  parameter int LEN_HI   = 224,
  parameter int LEN_LO60 = 508,
  parameter int LEN_LO50 = 512
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          h_o,
  input logic          hsync_o,
  input logic          sol_o,
  input logic [CW-1:0] line_len_o,
  input logic [CW-1:0] cnt,
  input logic [PW-1:0] phase_q
);

  assert_sol_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sol_o |=> !sol_o);

  assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_len_o == CW'(LEN_HI)) || (line_len_o == CW'(LEN_LO60)) || (line_len_o == CW'(LEN_LO50)));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < line_len_o);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == line_len_o - CW'(1)) |=> sol_o);

  assert_sync_kills_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_o) |-> !h_o);

  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
    por_n |=> $stable(phase_q));

endmodule

bind hdt_timing hdt_timing_chk #(
  .CW(CW), .PW(PW), .LEN_HI(LEN_HI), .LEN_LO60(LEN_LO60), .LEN_LO50(LEN_LO50)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .h_o        (h_o),
  .hsync_o    (hsync_o),
  .sol_o      (sol_o),
  .line_len_o (line_len_o),
  .cnt        (cnt),
  .phase_q    (phase_q)
);

// File: tb/hdt_timing_bench.sv
module hdt_timing_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase_i = 2'd0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [1:0] wr_data = 2'd0;
  logic       h_o, blank_o, hsync_o, sol_o;
  logic [9:0] line_len_o;

  int checks = 0;
  int failures = 0;

  hdt_timing u_hdt_timing (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .phase_i(phase_i),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .h_o(h_o), .blank_o(blank_o), .hsync_o(hsync_o),
    .sol_o(sol_o), .line_len_o(line_len_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Line monitor: position in line and first edge of each output
  int pos = 0;
  int cur_hr = -1, cur_hf = -1, cur_br = -1, cur_bf = -1, cur_sr = -1, cur_sf = -1;
  int last_hr, last_hf, last_br, last_bf, last_sr, last_sf, last_len;
  logic h_p = 1'b0, b_p = 1'b1, s_p = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pos = 0; h_p = h_o; b_p = blank_o; s_p = hsync_o;
    end else begin
      if (sol_o) begin
        last_hr = cur_hr; last_hf = cur_hf; last_br = cur_br;
        last_bf = cur_bf; last_sr = cur_sr; last_sf = cur_sf;
        last_len = pos + 1;
        pos = 0;
        cur_hr = -1; cur_hf = -1; cur_br = -1; cur_bf = -1; cur_sr = -1; cur_sf = -1;
      end else begin
        pos++;
      end
      if (h_o && !h_p && cur_hr < 0) cur_hr = pos;
      if (!h_o && h_p && cur_hf < 0) cur_hf = pos;
      if (blank_o && !b_p && cur_br < 0) cur_br = pos;
      if (!blank_o && b_p && cur_bf < 0) cur_bf = pos;
      if (hsync_o && !s_p && cur_sr < 0) cur_sr = pos;
      if (!hsync_o && s_p && cur_sf < 0) cur_sf = pos;
      h_p = h_o; b_p = blank_o; s_p = hsync_o;
    end
  end

  task automatic check(input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, got, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic power_up(input logic [1:0] ph);
    por_n = 1'b0; rst_n = 1'b0; phase_i = ph;
    repeat (4) tick();
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic wait_sol;
    do tick(); while (pos != 0);
  endtask

  task automatic wr_at(input int k, input logic sel, input logic [1:0] d);
    while (pos != k) tick();
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    por_n = 1'b0; rst_n = 1'b0; phase_i = 2'd0;
    repeat (4) tick();
    check(h_o, 0, "R1 h in reset");
    check(blank_o, 1, "R1 blank in reset");
    check(hsync_o, 0, "R1 hsync in reset");
    check(line_len_o, 508, "R1 length in reset");
    check(sol_o, 1, "R1 counter zero in reset");
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic t_default;
    wait_sol(); wait_sol();
    check(last_hr, 54, "R4 60Hz h rise");
    check(last_hf, 374, "R5 60Hz h fall");
    check(last_bf, 32, "R6 blank release");
    check(last_br, 452, "R6 low-res blank set");
    check(last_sr, 464, "R7 hsync rise");
    check(last_sf, 504, "R7 hsync fall");
    check(last_len, 508, "R3 60Hz length");
    tick();
    check(sol_o, 0, "R11 sol one cycle");
  endtask

  task automatic t_pal;
    wait_sol(); wr_at(100, 1'b1, 2'd2); wait_sol(); wait_sol();
    check(last_hr, 58, "R4 50Hz h rise");
    check(last_hf, 378, "R5 50Hz h fall");
    check(last_len, 512, "R3 50Hz length");
    check(last_sf, 504, "R7 hsync fall 50Hz");
  endtask

  task automatic t_freq_edge;
    // rate written in 371 is seen by point 372
    wait_sol(); wr_at(371, 1'b1, 2'd0); wait_sol();
    check(last_hf, 374, "R8 rate write before point clears h");
    check(last_len, 512, "R3 length kept after late rate change");
    wait_sol(); wr_at(100, 1'b1, 2'd2); wait_sol();
    // rate written in 372 misses point 372 and fails 376: hsync ends it
    wr_at(372, 1'b1, 2'd0); wait_sol();
    check(last_hr, 58, "R2 rate write effective next line");
    check(last_hf, 464, "R8 R7 rate write at point, hsync clears h");
  endtask

  task automatic t_res_edge;
    wait_sol(); wr_at(164, 1'b0, 2'd2); wr_at(300, 1'b0, 2'd0); wait_sol();
    check(last_hf, 166, "R8 R5 res write before read cycle");
    check(last_br, 186, "R6 high-res blank set");
    wait_sol(); wr_at(165, 1'b0, 2'd2); wr_at(300, 1'b0, 2'd0); wait_sol();
    check(last_hf, 374, "R8 res write in read cycle missed");
  endtask

  task automatic t_blank_supp;
    wait_sol(); wr_at(10, 1'b0, 2'd2); wr_at(40, 1'b0, 2'd0); wait_sol();
    check(last_bf, -1, "R6 blank kept with high res at 30");
    check(last_hr, -1, "R9 h set suppressed under blank");
    check(last_len, 508, "R3 length low res");
  endtask

  task automatic t_hires;
    wait_sol(); wr_at(100, 1'b0, 2'd2); wait_sol(); wait_sol();
    check(last_hr, 6, "R4 high-res h rise");
    check(last_hf, 166, "R5 high-res h fall");
    check(last_sr, -1, "R7 no hsync in high res");
    check(last_len, 224, "R3 high-res length");
    wait_sol(); wr_at(200, 1'b0, 2'd0); wait_sol(); wait_sol();
    check(last_len, 508, "R3 back to low res length");
    check(last_hr, 54, "R4 back to low res h rise");
  endtask

  task automatic t_phase3;
    power_up(2'd3);
    wait_sol(); wr_at(100, 1'b1, 2'd2); wait_sol(); wait_sol();
    check(last_hr, 61, "R4 R10 phase 3 h rise");
    check(last_hf, 381, "R5 R10 phase 3 h fall");
    check(last_bf, 35, "R6 R10 phase 3 blank release");
    check(last_sf, 507, "R7 R10 phase 3 hsync fall");
    check(last_len, 512, "R3 phase 3 length");
  endtask

  task automatic t_phase_keep;
    power_up(2'd2);
    phase_i = 2'd0;
    rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1;
    wait_sol(); wait_sol();
    check(last_hr, 56, "R10 phase kept through reset, rise");
    check(last_hf, 376, "R10 phase kept through reset, fall");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_default();
    t_pal();
    t_freq_edge();
    t_res_edge();
    t_blank_supp();
    t_hires();
    t_phase3();
    t_phase_keep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule